// File: doc/BRIEF.md
# Dual-Modulus Clock Prescaler

This block divides its input clock by one of two neighbouring integers, N or N+1. The pair is fixed when the block is elaborated and can be 5/6, 8/9 or 10/11. A wide-input OR of the modulus-control enables picks the divisor for each output period. Any enable that is high gives the short period N. The long period N+1 is used only when every enable is low. An external pulse-swallow counter can therefore steer the division ratio period by period, as it would in a frequency synthesizer loop.

The block samples the combined enables once per output period, on the clock edge that closes that period. The value it samples sets the length of the period that follows. A change to the enables at any other time waits for the next period boundary, so the block never produces a partial count. For 5/6, a small core counter sets the whole period. For 8/9 and 10/11, a half-size core (4/5 or 5/6) feeds a toggle stage. The extra count can only be added while the toggle stage is in its second half, so the high phase of the output has the same length whatever the modulus.

The divided output and a one-cycle terminal pulse both come from registers. The terminal pulse is high in the same cycle as each rising edge of the divided output. No data stream passes through the block, so it has no valid/ready handshake. All of its pins are plain control and clock-domain signals.

Top module: `dmod_prescaler`

## Requirements
- R1: The parameter LOW_DIV selects the modulus pair: 5 gives 5/6, 8 gives 8/9 and 10 gives 10/11. Any other value stops elaboration with an error.
- R2: If at least one bit of en_i is high when a period is sampled, the next output period lasts LOW_DIV input clocks.
- R3: If every bit of en_i is low when a period is sampled, the next output period lasts LOW_DIV+1 input clocks.
- R4: Each enable bit on its own, with the other bits held low, is enough to force the short period LOW_DIV. A bit that is tied low never forces the short period.
- R5: en_i is sampled only on the clock edge where tc_o becomes high, and that sample sets the length of the next period. Changes to en_i between two such edges have no effect on the period in progress.
- R6: While rst_i is high, div_o and tc_o are low. After rst_i falls, the first tc_o comes exactly P rising edges later, where P comes from R2/R3 using en_i at the last edge on which reset was held.
- R7: tc_o is high for exactly one input clock per output period, in the same cycle in which div_o changes from low to high.
- R8: div_o stays high for LOW_DIV/2 input clocks (2 for the 5/6 pair) from its rising edge, whatever the modulus. It is low for the rest of the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | EN_W (5) | Modulus-control enables; any high bit selects the short divisor |
| div_o | output | 1 | Registered divided clock |
| tc_o | output | 1 | One-cycle terminal pulse, aligned with each rising edge of div_o |

## Verification
A corrupted core count or toggle phase shows at the ports within one output period. It appears as a period between tc_o pulses that matches neither N nor N+1, or as a high phase of div_o with the wrong length. A fault in the modulus latch shows at the next tc_o as a period that disagrees with the enables sampled at the previous tc_o edge. For this reason the bench keeps a queue of expected lengths, one entry added at each period boundary. A misaligned output register breaks the pairing of tc_o with the rising edge of div_o in the very cycle it happens.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

  // Lower divisors the block can build.
  function automatic bit low_div_ok(int low);
    return (low == 5) || (low == 8) || (low == 10);
  endfunction

  // Toggle stage present for the 8/9 and 10/11 pairs.
  function automatic bit has_toggle(int low);
    return low != 5;
  endfunction

  // Length of the short core cycle.
  function automatic int core_len(int low);
    return has_toggle(low) ? (low / 2) : low;
  endfunction

  // Width of the core counter, enough to hold core_len.
  function automatic int core_w(int low);
    return $clog2(core_len(low) + 1);
  endfunction

endpackage

// File: rtl/dmp_modsel.sv
module dmp_modsel #(
  parameter int EN_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [EN_W-1:0] en_i,
  input  logic            sample_i,
  output logic            stretch_o
);

  // Wide OR of the enables, inverted: stretch (N+1) only when all are low.
  logic any_en;
  assign any_en = |en_i;

  // Latched once per period, at the period boundary or during reset.
  always_ff @(posedge clk_i) begin
    if (rst_i || sample_i) begin
      stretch_o <= ~any_en;
    end
  end

  // Outside a boundary the latched modulus must not move.
  AST_STRETCH_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    !sample_i |=> $stable(stretch_o)); // R5

endmodule

// File: rtl/dmp_core.sv
module dmp_core #(
  parameter int LOW_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic stretch_i,
  output logic period_end_o,
  output logic half_end_o
);
  import dmp_pkg::*;

  localparam int CLEN = core_len(LOW_DIV);
  localparam int CW   = core_w(LOW_DIV);
  localparam logic [CW-1:0] LAST = CW'(CLEN - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;
  logic          ext_now;

  assign wrap = (cnt_q == (LAST + {{(CW-1){1'b0}}, ext_now}));

  always_ff @(posedge clk_i) begin
    if (rst_i || wrap) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (has_toggle(LOW_DIV)) begin : g_toggle
      // Toggle stage: second half may take the extra count.
      logic ph_q;
      always_ff @(posedge clk_i) begin
        if (rst_i)     ph_q <= 1'b0;
        else if (wrap) ph_q <= ~ph_q;
      end
      assign ext_now      = stretch_i & ph_q;
      assign period_end_o = wrap & ph_q;
      assign half_end_o   = wrap & ~ph_q;

      AST_FIRST_HALF_SHORT: assert property (@(posedge clk_i) disable iff (rst_i)
        !ph_q |-> cnt_q <= LAST); // R8
    end else begin : g_flat
      // Flat core: the whole period comes from the counter.
      assign ext_now      = stretch_i;
      assign period_end_o = wrap;
      assign half_end_o   = (cnt_q == CW'(1));
    end
  endgenerate

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= LAST + 1'b1); // R3

endmodule

// File: rtl/dmp_outreg.sv
module dmp_outreg (
  input  logic clk_i,
  input  logic rst_i,
  input  logic period_end_i,
  input  logic half_end_i,
  output logic div_o,
  output logic tc_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      div_o <= 1'b0;
      tc_o  <= 1'b0;
    end else begin
      tc_o <= period_end_i;
      if (period_end_i)    div_o <= 1'b1;
      else if (half_end_i) div_o <= 1'b0;
    end
  end

  AST_TC_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    tc_o |=> !tc_o); // R7

  AST_TC_AT_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
    tc_o |-> (div_o && !$past(div_o))); // R7

  AST_FALL_AT_HALF: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(div_o) |-> $past(half_end_i)); // R8

endmodule

// File: rtl/dmod_prescaler.sv
module dmod_prescaler #(
  parameter int LOW_DIV = 8,
  parameter int EN_W    = 5
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [EN_W-1:0] en_i,
  output logic            div_o,
  output logic            tc_o
);
  import dmp_pkg::*;

  generate
    if (!low_div_ok(LOW_DIV)) begin : g_bad_div
      $error("dmod_prescaler: LOW_DIV must be 5, 8 or 10"); // R1
    end
  endgenerate

  logic stretch;
  logic period_end;
  logic half_end;

  dmp_modsel #(.EN_W(EN_W)) modsel_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_i      (en_i),
    .sample_i  (period_end),
    .stretch_o (stretch)
  );

  dmp_core #(.LOW_DIV(LOW_DIV)) core_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .stretch_i    (stretch),
    .period_end_o (period_end),
    .half_end_o   (half_end)
  );

  dmp_outreg outreg_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .period_end_i (period_end),
    .half_end_i   (half_end),
    .div_o        (div_o),
    .tc_o         (tc_o)
  );

  AST_END_NOT_HALF: assert property (@(posedge clk_i) disable iff (rst_i)
    !(period_end && half_end)); // R8

endmodule

// File: tb/dmod_prescaler_tb_top.sv
module dmod_prescaler_tb_mon #(
  parameter int N = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] en,
  input  logic       tc,
  input  logic       div,
  input  logic [1:0] phase,
  output int         checks,
  output int         errs,
  output int         periods
);
  localparam int HIGH = (N == 5) ? 2 : N / 2;

  int    q[$];
  int    cyc, last_tc, hcnt, e;
  logic  prev_div, prev_tc, prev_rst;
  bit    first;
  string tag;

  initial begin
    checks = 0; errs = 0; periods = 0;
    prev_rst = 1'b0; prev_div = 1'b0; prev_tc = 1'b0;
    cyc = 0; last_tc = 0; hcnt = 0; first = 1'b1;
  end

  function automatic int exp_len(logic [4:0] v);
    return (|v) ? N : N + 1;
  endfunction

  task automatic chk(bit ok, string t, int act, int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s (N=%0d) at cycle %0d: actual %0d expected %0d",
               t, N, cyc, act, expv);
    end
  endtask

  // Sampled at the falling edge; the driver changes en only after it.
  always @(negedge clk) begin
    if (rst) begin
      if (!prev_rst) begin
        chk(tc == 1'b0,  "R6 tc_o low in reset",  int'(tc),  0);
        chk(div == 1'b0, "R6 div_o low in reset", int'(div), 0);
      end
      q.delete();
      q.push_back(exp_len(en));
      cyc = 0; last_tc = 0; hcnt = 0;
      prev_div = 1'b0; prev_tc = 1'b0; first = 1'b1;
    end else begin
      cyc++;
      if (tc) begin
        chk(div && !prev_div, "R7 tc_o with div_o rise", int'(div), 1);
        chk(!prev_tc, "R7 tc_o single cycle", int'(prev_tc), 0);
        if (q.size() == 0) begin
          chk(1'b0, "R5 no expected period queued", 0, 1);
        end else begin
          e = q.pop_front();
          if (first)           tag = "R6 first period";
          else if (phase == 2) tag = "R5 period after random enables";
          else if (phase == 1) tag = "R4 single enable bit";
          else if (e == N)     tag = "R2 short period";
          else                 tag = "R3 long period";
          chk((cyc - last_tc) == e, tag, cyc - last_tc, e);
          periods++;
        end
        last_tc = cyc;
        first   = 1'b0;
        q.push_back(exp_len(en));
      end
      if (div) hcnt++;
      else if (prev_div) begin
        chk(hcnt == HIGH, "R8 div_o high length", hcnt, HIGH);
        hcnt = 0;
      end
      prev_div = div;
      prev_tc  = tc;
    end
    prev_rst = rst;
  end

endmodule

module dmod_prescaler_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] en  = 5'b0;
  logic [1:0] phase = 2'd0;
  bit         done = 1'b0;

  logic div8, tc8, div5, tc5, div10, tc10;
  int c8, e8, p8, c5, e5, p5, c10, e10, p10;
  int checks, errors;

  always #5 clk = ~clk;

  dmod_prescaler #(.LOW_DIV(8)) dut_i (
    .clk_i(clk), .rst_i(rst), .en_i(en), .div_o(div8), .tc_o(tc8));
  dmod_prescaler #(.LOW_DIV(5)) dut5_i (
    .clk_i(clk), .rst_i(rst), .en_i(en), .div_o(div5), .tc_o(tc5));
  dmod_prescaler #(.LOW_DIV(10)) dut10_i (
    .clk_i(clk), .rst_i(rst), .en_i(en), .div_o(div10), .tc_o(tc10));

  dmod_prescaler_tb_mon #(.N(8)) mon8_i (
    .clk(clk), .rst(rst), .en(en), .tc(tc8), .div(div8), .phase(phase),
    .checks(c8), .errs(e8), .periods(p8));
  dmod_prescaler_tb_mon #(.N(5)) mon5_i (
    .clk(clk), .rst(rst), .en(en), .tc(tc5), .div(div5), .phase(phase),
    .checks(c5), .errs(e5), .periods(p5));
  dmod_prescaler_tb_mon #(.N(10)) mon10_i (
    .clk(clk), .rst(rst), .en(en), .tc(tc10), .div(div10), .phase(phase),
    .checks(c10), .errs(e10), .periods(p10));

  task automatic hold_en(logic [4:0] v, int cycles);
    @(negedge clk); #1 en = v;
    repeat (cycles - 1) @(negedge clk);
  endtask

  task automatic do_reset(logic [4:0] v);
    @(negedge clk); #1 rst = 1'b1; en = v;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic r1_check(int per, int n);
    checks++;
    if (per < 20) begin
      errors++;
      $display("FAIL R1 pair %0d/%0d: actual %0d periods expected at least %0d",
               n, n + 1, per, 20);
    end
  endtask

  task automatic finish_run();
    checks = checks + c8 + c5 + c10;
    errors = errors + e8 + e5 + e10;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    checks = 0; errors = 0;
    // Reset with all enables low: first period long (R6, R3).
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    hold_en(5'b00000, 80);      // R3
    hold_en(5'b00100, 80);      // R2
    hold_en(5'b11111, 60);      // R2
    phase = 2'd1;
    for (int b = 0; b < 5; b++) hold_en(5'b00001 << b, 60); // R4
    phase = 2'd0;
    hold_en(5'b00000, 40);
    phase = 2'd2;
    for (int k = 0; k < 3000; k++) begin // R5: en changes every cycle
      @(negedge clk); #1 en = ($urandom_range(1, 0) == 0) ? 5'b0 : 5'($urandom);
    end
    phase = 2'd0;
    do_reset(5'b01000);         // R6: first period short
    hold_en(5'b01000, 60);
    do_reset(5'b00000);         // R6: first period long
    hold_en(5'b00000, 60);
    r1_check(p8, 8);
    r1_check(p5, 5);
    r1_check(p10, 10);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule